// File: doc/BRIEF.md
# Key-Protected System Control Register

This block is one 32-bit control register on a simple synchronous register bus. The bus has an address, a write strobe, write data, a read strobe and read data. Any write that does not carry a fixed 16-bit unlock value in its upper half-word is thrown away whole, lower bits included. A read returns a different fixed 16-bit signature in the upper half-word. The register stores a 3-bit priority-grouping field and shows a read-only byte-order status bit, which is set by a parameter. The grouping field is exported to whatever logic later splits interrupt priorities.

Three low bits are commands and hold no data. Setting bit 2 in an accepted write raises a system reset request line toward the outside. That line stays high until the block itself is reset, so a slow external reset controller can sample it. Bits 1 and 0 are debug controls that software must write as zero. If an accepted write sets either of them, the bit is ignored and a sticky misuse flag goes high. All three command bits read back as zero. Read data is registered and appears one clock after the read strobe.

Top module: `keyed_sysctl_reg`

## Requirements
- R1: After reset, `grp_field` is 0, `sys_reset_req` is 0, `dbg_misuse_err` is 0 and `bus_rdata` is 0.
- R2: A write to the register address whose `bus_wdata[31:16]` is not 16'h05FA changes nothing. The grouping field keeps its value, and neither the reset request nor the misuse flag is raised, whatever the lower bits carry.
- R3: A read of the register address returns 16'hFA05 in `bus_rdata[31:16]`.
- R4: `bus_rdata[15]` equals the `BIG_ENDIAN` parameter, where 0 means little-endian and 1 means big-endian. Writing bit 15 has no effect on it.
- R5: An accepted write (upper half-word 16'h05FA) loads `bus_wdata[10:8]` into the grouping field. The new value shows on `grp_field` after that clock edge and is returned in `bus_rdata[10:8]` by later reads.
- R6: An accepted write with `bus_wdata[2]` = 1 drives `sys_reset_req` high after that clock edge. The line stays high until `rst_n` is asserted.
- R7: An accepted write with `bus_wdata[1]` or `bus_wdata[0]` set raises `dbg_misuse_err` after that clock edge, and the flag stays high until reset. Those two bits change nothing else, and the rest of the write still applies.
- R8: `bus_rdata` bits [14:11] and [7:0] always read 0. This includes the command bits 2, 1 and 0.
- R9: Read data is registered. `bus_rdata` updates one clock after `bus_re` is sampled, a read of any other address returns 0, and `bus_rdata` holds its value while `bus_re` is low.
- R10: A write to any address other than `REG_ADDR` has no effect, even when it carries the unlock value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| grp_field | output | 3 | Priority-grouping field value |
| sys_reset_req | output | 1 | Sticky system reset request |
| dbg_misuse_err | output | 1 | Sticky flag for nonzero debug bits in an accepted write |

## Verification
Directed writes use upper half-words that are wrong, that equal the read signature, and that equal the unlock value. Together these show whether the gate compares against the right constant and whether a refused write also discards its low bits. Further writes target foreign addresses or set bit 15 alone, bit 2 alone, or a debug bit alone. Each one shows which single field or output reacts to that bit. After that, a fixed-seed random mix of keyed and unkeyed writes and reads is compared with a bench model, and a mid-run reset confirms that the sticky outputs clear only through reset.

// File: rtl/keyed_sysctl_pkg.sv
package keyed_sysctl_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned GRP_W   = 3;
  localparam int unsigned GRP_LSB = 8;
  localparam int unsigned RST_BIT = 2;
  localparam int unsigned END_BIT = 15;

  localparam logic [HALF_W-1:0] UNLOCK_VAL = 16'h05FA;
  localparam logic [HALF_W-1:0] READ_SIG   = 16'hFA05;

  typedef struct packed {
    logic             accept;
    logic [GRP_W-1:0] grp;
    logic             rst_cmd;
    logic             dbg_cmd;
  } wr_cmd_t;

  function automatic logic key_matches(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: HALF_W] == UNLOCK_VAL;
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(input logic [DATA_W-1:0] w);
    return w[GRP_LSB +: GRP_W];
  endfunction

  function automatic logic dbg_bits_set(input logic [DATA_W-1:0] w);
    return w[1] | w[0];
  endfunction

  function automatic logic [DATA_W-1:0] pack_read(input logic be,
                                                  input logic [GRP_W-1:0] g);
    return {READ_SIG, be, 4'b0000, g, 8'h00};
  endfunction

endpackage

// File: rtl/keyed_sysctl_decode.sv
module keyed_sysctl_decode
  import keyed_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output wr_cmd_t           wr_cmd,
  output logic              wr_refused,
  output logic              rd_hit,
  output logic              rd_miss
);

  logic addr_hit;

  assign addr_hit   = bus_addr == REG_ADDR;
  assign rd_hit     = bus_re & addr_hit;
  assign rd_miss    = bus_re & ~addr_hit;
  assign wr_refused = bus_we & addr_hit & ~key_matches(bus_wdata);

  always_comb begin
    wr_cmd.accept  = bus_we & addr_hit & key_matches(bus_wdata);
    wr_cmd.grp     = grp_of(bus_wdata);
    wr_cmd.rst_cmd = bus_wdata[RST_BIT];
    wr_cmd.dbg_cmd = dbg_bits_set(bus_wdata);
  end

  // R2
  refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refused |-> !wr_cmd.accept);

endmodule

// File: rtl/keyed_sysctl_state.sv
module keyed_sysctl_state
  import keyed_sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_cmd_t          wr_cmd,
  input  logic             wr_refused,
  output logic [GRP_W-1:0] grp_q,
  output logic             rst_req_q,
  output logic             dbg_err_q
);

  logic rst_set_ev;
  logic dbg_set_ev;

  assign rst_set_ev = wr_cmd.accept & wr_cmd.rst_cmd;
  assign dbg_set_ev = wr_cmd.accept & wr_cmd.dbg_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q     <= '0;
      rst_req_q <= 1'b0;
      dbg_err_q <= 1'b0;
    end else begin
      if (wr_cmd.accept) grp_q <= wr_cmd.grp;
      if (rst_set_ev)    rst_req_q <= 1'b1;
      if (dbg_set_ev)    dbg_err_q <= 1'b1;
    end
  end

  // R2
  refused_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd.accept |=> $stable(grp_q));

  // R2
  refused_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_refused && !rst_req_q) |=> !rst_req_q);

  // R5
  grp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd.accept |=> grp_q == $past(wr_cmd.grp));

  // R6
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_set_ev |=> rst_req_q);

  // R6
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);

  // R7
  dbg_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_set_ev |=> dbg_err_q);

  // R7
  dbg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_err_q |=> dbg_err_q);

endmodule

// File: rtl/keyed_sysctl_readback.sv
module keyed_sysctl_readback
  import keyed_sysctl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              rd_miss,
  input  logic [GRP_W-1:0]  grp_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_hit)  rdata_q <= pack_read(BIG_ENDIAN, grp_q);
    else if (rd_miss) rdata_q <= '0;
  end

  // R3
  sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rdata_q[31:16] == READ_SIG);

  // R4
  endian_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rdata_q[END_BIT] == BIG_ENDIAN);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[14:11] == 4'b0000 && rdata_q[7:0] == 8'h00);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit || rd_miss) |=> $stable(rdata_q));

endmodule

// File: rtl/keyed_sysctl_reg.sv
module keyed_sysctl_reg
  import keyed_sysctl_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h0C,
  parameter bit                BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [2:0]        grp_field,
  output logic              sys_reset_req,
  output logic              dbg_misuse_err
);

  wr_cmd_t          wr_cmd;
  logic             wr_refused;
  logic             rd_hit;
  logic             rd_miss;
  logic [GRP_W-1:0] grp_q;

  keyed_sysctl_decode #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) decode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_re     (bus_re),
    .wr_cmd     (wr_cmd),
    .wr_refused (wr_refused),
    .rd_hit     (rd_hit),
    .rd_miss    (rd_miss)
  );

  keyed_sysctl_state state_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_refused (wr_refused),
    .grp_q      (grp_q),
    .rst_req_q  (sys_reset_req),
    .dbg_err_q  (dbg_misuse_err)
  );

  keyed_sysctl_readback #(
    .BIG_ENDIAN (BIG_ENDIAN)
  ) readback_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (rd_hit),
    .rd_miss (rd_miss),
    .grp_q   (grp_q),
    .rdata_q (bus_rdata)
  );

  assign grp_field = grp_q;

  // R10
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != REG_ADDR) |=> $stable(grp_field));

endmodule

// File: tb/keyed_sysctl_reg_tb_top.sv
module keyed_sysctl_reg_tb_top;

  localparam logic [7:0] REG_A = 8'h0C;
  localparam logic [7:0] OTHER_A = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  grp_field;
  logic        sys_reset_req;
  logic        dbg_misuse_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_grp;
  logic       m_req;
  logic       m_err;
  logic [31:0] m_rd;

  always #5 clk = ~clk;

  keyed_sysctl_reg dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .grp_field      (grp_field),
    .sys_reset_req  (sys_reset_req),
    .dbg_misuse_err (dbg_misuse_err)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] g);
    logic [31:0] v;
    v = 32'h0;
    v[31:16] = 16'hFA05;
    v[15]    = 1'b0;
    v[10:8]  = g;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " grp"}, {29'h0, grp_field}, {29'h0, m_grp});
    chk({req, " req"}, {31'h0, sys_reset_req}, {31'h0, m_req});
    chk({req, " err"}, {31'h0, dbg_misuse_err}, {31'h0, m_err});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == REG_A && d[31:16] == 16'h05FA) begin
      m_grp = d[10:8];
      if (d[2]) m_req = 1'b1;
      if (d[1] | d[0]) m_err = 1'b1;
    end
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    m_rd = (a == REG_A) ? exp_read(m_grp) : 32'h0;
    @(negedge clk);
    bus_re = 1'b0;
    chk(req, bus_rdata, m_rd);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_grp = '0; m_req = 1'b0; m_err = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_grp = '0; m_req = 1'b0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_outs("R1");
    chk("R1 rdata", bus_rdata, 32'h0);

    // R3 R4 R8 first read
    do_read(REG_A, "R3 R4 R8 read after reset");

    // R2 wrong key, low bits would otherwise act
    do_write(REG_A, 32'h0000_0707);
    chk_outs("R2 zero key");
    do_write(REG_A, 32'hFA05_0607);
    chk_outs("R2 signature as key");
    do_read(REG_A, "R2 readback");

    // R5 keyed grouping write
    do_write(REG_A, 32'h05FA_0500);
    chk_outs("R5 grp=5");
    do_read(REG_A, "R5 readback grp=5");

    // R4 bit 15 not writable
    do_write(REG_A, 32'h05FA_8300);
    chk_outs("R4 write bit15");
    do_read(REG_A, "R4 bit15 stays 0");

    // R10 foreign address keyed write
    do_write(OTHER_A, 32'h05FA_0707);
    chk_outs("R10 foreign write");

    // R9 foreign read gives 0, then hold
    do_read(REG_A, "R9 read before miss");
    do_read(OTHER_A, "R9 foreign read zero");
    do_read(REG_A, "R9 read again");
    repeat (3) @(negedge clk);
    chk("R9 hold while idle", bus_rdata, m_rd);

    // R7 debug bit misuse
    do_write(REG_A, 32'h05FA_0602);
    chk_outs("R7 bit1");
    do_read(REG_A, "R7 R8 readback");
    do_write(REG_A, 32'h05FA_0101);
    chk_outs("R7 bit0 still sticky");

    // R6 reset request
    do_write(REG_A, 32'h05FA_0404);
    chk_outs("R6 bit2 raise");
    do_read(REG_A, "R6 R8 bit2 reads 0");
    do_write(REG_A, 32'h05FA_0200);
    chk_outs("R6 stays after keyed write");
    do_write(REG_A, 32'h1234_0000);
    chk_outs("R6 stays after refused write");

    // R1 R6 R7 reset clears sticky outputs
    apply_reset();
    @(negedge clk);
    chk_outs("R1 R6 R7 after reset");
    chk("R1 rdata after reset", bus_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      d = $urandom;
      if ($urandom_range(1, 0) == 1) d[31:16] = 16'h05FA;
      if ($urandom_range(7, 0) != 0) d[2:0] = 3'b000;
      case ($urandom_range(3, 0))
        0: do_write(REG_A, d);
        1: do_write(($urandom_range(1, 0) == 1) ? OTHER_A : REG_A, d);
        2: do_read(REG_A, "R3 R5 R8 random read");
        default: do_read(($urandom_range(3, 0) == 0) ? OTHER_A : REG_A, "R9 random read");
      endcase
      chk_outs("R2 R5 R6 R7 random");
      if (i == 200) begin
        apply_reset();
        @(negedge clk);
        chk_outs("R1 random reset");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule